// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a virtual address into a physical address within a single cycle. It holds two one-way translation caches, one for instruction fetches and one for loads and stores. Each has a tag word and a translation word per slot. A lookup takes the virtual address, the access kind and the privilege mode, and combinationally returns a physical address, the permissions granted and a two-bit result code.

When the caller raises a fault strobe, a small recorder classifies any failed lookup into one of four exceptions: instruction miss, data miss, instruction page fault or data page fault. On the same clock edge it captures the offending virtual address. Each side can be switched to pass-through, where addresses go out untranslated with full rights.

Software fills entries through a single write port. The port picks the side, the slot and which of the two words to write.

Top module: `tlb_xlate_unit`

## Requirements
- R1: After reset every tag and translation word is zero, `exc_o` is 0 and `eear_o` is 0. So a translated lookup in virtual page 0 returns invalid (2), and any other page returns no-match (1).
- R2: The slot is VPN[5:0], where VPN = va[31:13]. If tag word bits [31:13] differ from the VPN, `res_o` is no-match (1), and `pa_o` and `perm_o` are 0.
- R3: If the tag bits equal the VPN but tag word bit 0 (valid) is clear, `res_o` is invalid (2), and `pa_o` and `perm_o` are 0.
- R4: Rights come from the translation word. With `sup_i`=1, execute and read come from bit 6 and write from bit 8. With `sup_i`=0, execute and read come from bit 7 and write from bit 9. A fetch without execute, a load without read or a store without write gives bad-address (3), with `pa_o` and `perm_o` at 0.
- R5: On a translated match, `res_o` is 0 and `pa_o` is {translation word[31:13], va[12:0]}. `perm_o` is {x,w,r} (bit 2 execute, bit 1 write, bit 0 read). The instruction side reports only x. The data side reports only w and r.
- R6: When the selected side's enable (`code_xl_on_i` for fetches, `data_xl_on_i` otherwise) is 0, `pa_o` equals `va_i`, `perm_o` is 3'b111 and `res_o` is match (0).
- R7: `acc_i` encodes 00 load, 01 store, 1x fetch. Fetches look up the instruction side only. Loads and stores look up the data side only.
- R8: With `wr_en_i`=1, `wr_side_i` (1 instruction, 0 data), `wr_idx_i` and `wr_sel_i` (0 tag word, 1 translation word) choose the word that takes `wr_data_i` at the clock edge. A lookup in the same cycle still sees the old word.
- R9: On a clock edge with `flt_strobe_i`=1 and a non-match result, `eear_o` takes `va_i` and `exc_o` takes a code. The codes are 1 for an instruction miss and 2 for a data miss, both from no-match or invalid. They are 3 for an instruction page fault and 4 for a data page fault, both from bad-address.
- R10: `exc_o` and `eear_o` hold when `flt_strobe_i` is 0 or when the result is match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_xl_on_i | input | 1 | Translate fetches (0 = pass-through) |
| data_xl_on_i | input | 1 | Translate loads and stores (0 = pass-through) |
| va_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| sup_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| pa_o | output | 32 | Physical address |
| perm_o | output | 3 | Granted rights {x,w,r} |
| res_o | output | 2 | 0 match, 1 no-match, 2 invalid, 3 bad-address |
| flt_strobe_i | input | 1 | Record a fault for this cycle's lookup |
| exc_o | output | 3 | Latched exception code |
| eear_o | output | 32 | Latched faulting virtual address |
| wr_en_i | input | 1 | Entry write enable |
| wr_side_i | input | 1 | 1 instruction side, 0 data side |
| wr_idx_i | input | 6 | Slot to write |
| wr_sel_i | input | 1 | 0 tag word, 1 translation word |
| wr_data_i | input | 32 | Word to write |

## Verification
An entry write and a fault capture can land on the same clock edge. In that case the recorded exception must come from the entry as it stood before the write, and only the next lookup sees the new word. The bench provokes this with directed cycles: a tag write meets a strobed miss on the same slot, and a translation-word write meets a lookup of the page it changes. A long random phase draws pages from a small pool, so writes, strobes and lookups keep colliding on the same slots. A behavioural model updated on each rising edge judges every cycle, comparing the combinational outputs and the latched exception state.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_INVAL = 2'd2,
        RES_BAD   = 2'd3
    } xres_e;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_DMISS = 3'd2,
        EXC_IPF   = 3'd3,
        EXC_DPF   = 3'd4
    } xexc_e;

    // translation word right bits
    localparam int unsigned BIT_SUP_XR = 6;
    localparam int unsigned BIT_USR_XR = 7;
    localparam int unsigned BIT_SUP_W  = 8;
    localparam int unsigned BIT_USR_W  = 9;

    // perm vector positions
    localparam int unsigned PERM_R = 0;
    localparam int unsigned PERM_W = 1;
    localparam int unsigned PERM_X = 2;

    localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned W       = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_sel_i,
    input  logic [W-1:0]     wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [W-1:0]     rd_tag_o,
    output logic [W-1:0]     rd_xl_o
);

    typedef struct packed {
        logic [W-1:0] tag;
        logic [W-1:0] xl;
    } ent_t;

    ent_t [ENTRIES-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_en_i) begin
            if (wr_sel_i) begin
                ent_d[wr_idx_i].xl = wr_data_i;
            end else begin
                ent_d[wr_idx_i].tag = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_tag_o = ent_q[rd_idx_i].tag;
    assign rd_xl_o  = ent_q[rd_idx_i].xl;

    // R8: a tag write is visible in the addressed slot on the next cycle
    assert_tag_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_sel_i) |=> (ent_q[$past(wr_idx_i)].tag == $past(wr_data_i)));

    // R8: a translation word write is visible on the next cycle
    assert_xl_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i) |=> (ent_q[$past(wr_idx_i)].xl == $past(wr_data_i)));

endmodule

// File: rtl/tlb_check.sv
module tlb_check
    import tlb_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 13,
    parameter bit          IS_CODE   = 1'b0
) (
    input  logic [ADDR_W-1:0] va_i,
    input  logic              is_store_i,
    input  logic              sup_i,
    input  logic [ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0] xl_i,
    output logic [1:0]        res_o,
    output logic [2:0]        perm_o,
    output logic [ADDR_W-1:0] pa_o
);

    localparam int unsigned VPN_W = ADDR_W - PAGE_BITS;

    logic [VPN_W-1:0] vpn;
    logic             tag_hit;
    logic             ent_valid;
    logic [2:0]       grant;
    logic             need_ok;
    logic             unused_bits;

    assign vpn       = va_i[ADDR_W-1:PAGE_BITS];
    assign tag_hit   = (tag_i[ADDR_W-1:PAGE_BITS] == vpn);
    assign ent_valid = tag_i[0];

    if (IS_CODE) begin : g_code
        logic can_x;
        assign can_x   = sup_i ? xl_i[BIT_SUP_XR] : xl_i[BIT_USR_XR];
        assign grant   = {can_x, 2'b00};
        assign need_ok = can_x;
    end else begin : g_data
        logic can_r, can_w;
        assign can_r   = sup_i ? xl_i[BIT_SUP_XR] : xl_i[BIT_USR_XR];
        assign can_w   = sup_i ? xl_i[BIT_SUP_W]  : xl_i[BIT_USR_W];
        assign grant   = {1'b0, can_w, can_r};
        assign need_ok = is_store_i ? can_w : can_r;
    end

    always_comb begin
        res_o = RES_HIT;
        if (!tag_hit) begin
            res_o = RES_MISS;
        end else if (!ent_valid) begin
            res_o = RES_INVAL;
        end else if (!need_ok) begin
            res_o = RES_BAD;
        end
    end

    always_comb begin
        pa_o   = '0;
        perm_o = '0;
        if (res_o == RES_HIT) begin
            pa_o   = {xl_i[ADDR_W-1:PAGE_BITS], va_i[PAGE_BITS-1:0]};
            perm_o = grant;
        end
    end

    assign unused_bits = ^{tag_i, xl_i, is_store_i};

endmodule

// File: rtl/tlb_fault_rec.sv
module tlb_fault_rec
    import tlb_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic [1:0]        res_i,
    input  logic              is_fetch_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic [2:0]        exc_o,
    output logic [ADDR_W-1:0] eear_o
);

    typedef struct packed {
        logic [2:0]        exc;
        logic [ADDR_W-1:0] eear;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (strobe_i && (res_i != RES_HIT)) begin
            rec_d.eear = va_i;
            if (res_i == RES_BAD) begin
                rec_d.exc = is_fetch_i ? EXC_IPF : EXC_DPF;
            end else begin
                rec_d.exc = is_fetch_i ? EXC_IMISS : EXC_DMISS;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign exc_o  = rec_q.exc;
    assign eear_o = rec_q.eear;

    // R9: faulting address captured
    assert_eear_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && res_i != RES_HIT) |=> (eear_o == $past(va_i)));

    // R9: fetch-side miss or invalid gives the instruction miss code
    assert_imiss_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && is_fetch_i && (res_i == RES_MISS || res_i == RES_INVAL))
        |=> (exc_o == EXC_IMISS));

    // R9: data-side bad address gives the data page fault code
    assert_dpf_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !is_fetch_i && res_i == RES_BAD) |=> (exc_o == EXC_DPF));

    // R10: nothing recorded without a strobed failure
    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strobe_i || res_i == RES_HIT) |=> ($stable(exc_o) && $stable(eear_o)));

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
    import tlb_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 13,
    parameter int unsigned ENTRIES   = 64,
    localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              code_xl_on_i,
    input  logic              data_xl_on_i,
    input  logic [ADDR_W-1:0] va_i,
    input  logic [1:0]        acc_i,
    input  logic              sup_i,
    output logic [ADDR_W-1:0] pa_o,
    output logic [2:0]        perm_o,
    output logic [1:0]        res_o,
    input  logic              flt_strobe_i,
    output logic [2:0]        exc_o,
    output logic [ADDR_W-1:0] eear_o,
    input  logic              wr_en_i,
    input  logic              wr_side_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i
);

    localparam int unsigned NSIDE = 2;   // 0 data, 1 code

    logic [IDX_W-1:0]  slot;
    logic              is_fetch;
    logic              is_store;
    logic              side_on;

    logic [ADDR_W-1:0] tag_w  [NSIDE];
    logic [ADDR_W-1:0] xl_w   [NSIDE];
    logic [ADDR_W-1:0] pa_w   [NSIDE];
    logic [1:0]        res_w  [NSIDE];
    logic [2:0]        perm_w [NSIDE];

    assign slot     = va_i[PAGE_BITS +: IDX_W];
    assign is_fetch = acc_i[1];
    assign is_store = !acc_i[1] && acc_i[0];
    assign side_on  = is_fetch ? code_xl_on_i : data_xl_on_i;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        tlb_bank #(
            .ENTRIES (ENTRIES),
            .W       (ADDR_W)
        ) u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_i && (wr_side_i == 1'(g))),
            .wr_idx_i  (wr_idx_i),
            .wr_sel_i  (wr_sel_i),
            .wr_data_i (wr_data_i),
            .rd_idx_i  (slot),
            .rd_tag_o  (tag_w[g]),
            .rd_xl_o   (xl_w[g])
        );

        tlb_check #(
            .ADDR_W    (ADDR_W),
            .PAGE_BITS (PAGE_BITS),
            .IS_CODE   (g == 1)
        ) u_chk (
            .va_i       (va_i),
            .is_store_i (is_store),
            .sup_i      (sup_i),
            .tag_i      (tag_w[g]),
            .xl_i       (xl_w[g]),
            .res_o      (res_w[g]),
            .perm_o     (perm_w[g]),
            .pa_o       (pa_w[g])
        );
    end

    always_comb begin
        if (!side_on) begin
            pa_o   = va_i;
            perm_o = PERM_ALL;
            res_o  = RES_HIT;
        end else begin
            pa_o   = pa_w[is_fetch];
            perm_o = perm_w[is_fetch];
            res_o  = res_w[is_fetch];
        end
    end

    tlb_fault_rec #(
        .ADDR_W (ADDR_W)
    ) u_rec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .strobe_i   (flt_strobe_i),
        .res_i      (res_o),
        .is_fetch_i (is_fetch),
        .va_i       (va_i),
        .exc_o      (exc_o),
        .eear_o     (eear_o)
    );

    // R5: page offset always survives a match
    assert_offset_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_o == RES_HIT) |-> (pa_o[PAGE_BITS-1:0] == va_i[PAGE_BITS-1:0]));

    // R4: a refused or missed lookup exposes no address or rights
    assert_fail_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_o != RES_HIT) |-> (perm_o == 3'b000 && pa_o == '0));

    // R7: a translated fetch match grants execute and nothing else
    assert_fetch_rights_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (side_on && is_fetch && res_o == RES_HIT) |-> (perm_o == 3'b100));

    // R6: pass-through never fails
    assert_bypass_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!side_on) |-> (res_o == RES_HIT && pa_o == va_i && perm_o == PERM_ALL));

endmodule

// File: tb/tlb_xlate_unit_tb_top.sv
module tlb_xlate_unit_tb_top;

    typedef struct packed {
        logic [1:0]  res;
        logic [31:0] pa;
        logic [2:0]  perm;
    } look_t;

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ci_on = 1'b1, cd_on = 1'b1;
    logic [31:0] va = '0;
    logic [1:0]  acc = LD;
    logic        sup = 1'b1;
    logic        flt = 1'b0;
    logic        wr_en = 1'b0, wr_side = 1'b0, wr_sel = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    logic [31:0] pa_o, eear_o;
    logic [2:0]  perm_o, exc_o;
    logic [1:0]  res_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_tag [2][64];
    logic [31:0] m_xl  [2][64];
    logic [2:0]  m_exc;
    logic [31:0] m_eear;

    always #4 clk = ~clk;   // 125 MHz

    tlb_xlate_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .code_xl_on_i(ci_on), .data_xl_on_i(cd_on),
        .va_i(va), .acc_i(acc), .sup_i(sup),
        .pa_o(pa_o), .perm_o(perm_o), .res_o(res_o),
        .flt_strobe_i(flt), .exc_o(exc_o), .eear_o(eear_o),
        .wr_en_i(wr_en), .wr_side_i(wr_side), .wr_idx_i(wr_idx),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data)
    );

    function automatic look_t ref_look(logic [31:0] a, logic [1:0] k, logic s);
        look_t r;
        int side, page, ix;
        logic [31:0] t, x;
        logic [2:0] g;
        logic ok;
        r = '0;
        side = k[1] ? 1 : 0;
        if ((side == 1 && !ci_on) || (side == 0 && !cd_on)) begin
            r.pa = a;
            r.perm = 3'b111;
            return r;
        end
        page = int'(a >> 13);
        ix = page % 64;
        t = m_tag[side][ix];
        x = m_xl[side][ix];
        if ((t >> 13) != (a >> 13)) begin r.res = 2'd1; return r; end
        if (!t[0]) begin r.res = 2'd2; return r; end
        if (side == 1) g = {(s ? x[6] : x[7]), 2'b00};
        else g = {1'b0, (s ? x[8] : x[9]), (s ? x[6] : x[7])};
        ok = (side == 1) ? g[2] : (k[0] ? g[1] : g[0]);
        if (!ok) begin r.res = 2'd3; return r; end
        r.pa = (x & 32'hFFFF_E000) | (a & 32'h0000_1FFF);
        r.perm = g;
        return r;
    endfunction

    // behavioural model state, advanced on each rising edge
    always @(posedge clk) begin : model
        look_t l;
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 64; i++) begin
                    m_tag[s][i] = '0;
                    m_xl[s][i]  = '0;
                end
            m_exc = '0;
            m_eear = '0;
        end else begin
            l = ref_look(va, acc, sup);
            if (flt && l.res != 2'd0) begin
                m_eear = va;
                if (l.res == 2'd3) m_exc = acc[1] ? 3'd3 : 3'd4;
                else m_exc = acc[1] ? 3'd1 : 3'd2;
            end
            if (wr_en) begin
                if (wr_sel) m_xl[wr_side][wr_idx] = wr_data;
                else m_tag[wr_side][wr_idx] = wr_data;
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic cyc(string tag);
        look_t e;
        string t;
        #1;
        e = ref_look(va, acc, sup);
        t = tag;
        if (t == "") begin
            if ((acc[1] && !ci_on) || (!acc[1] && !cd_on)) t = "R6";
            else case (e.res)
                2'd0: t = "R5";
                2'd1: t = "R2";
                2'd2: t = "R3";
                default: t = "R4";
            endcase
        end
        chk(t, "res",  32'(res_o),  32'(e.res));
        chk(t, "pa",   pa_o,        e.pa);
        chk(t, "perm", 32'(perm_o), 32'(e.perm));
        chk(t, "exc",  32'(exc_o),  32'(m_exc));
        chk(t, "eear", eear_o,      m_eear);
        @(negedge clk);
        wr_en = 1'b0;
        flt = 1'b0;
    endtask

    task automatic look(logic [31:0] a, logic [1:0] k, logic s);
        va = a; acc = k; sup = s;
    endtask

    task automatic wr(logic sd, logic [5:0] ix, logic sl, logic [31:0] d);
        wr_en = 1'b1; wr_side = sd; wr_idx = ix; wr_sel = sl; wr_data = d;
    endtask

    localparam logic [18:0] VPN_A = 19'h00A45;            // slot 5
    localparam logic [31:0] VA_A  = {VPN_A, 13'h0123};
    localparam logic [31:0] TAG_A = {VPN_A, 13'h0001};
    // pfn 71234, bit6=1 bit7=1 bit8=1 bit9=0
    localparam logic [31:0] XL_A  = {19'h71234, 13'h01C0};
    // pfn 0ABCD, bit6=1 only
    localparam logic [31:0] XL_I  = {19'h0ABCD, 13'h0040};
    localparam logic [31:0] VA_X  = VA_A ^ 32'h0010_0000; // same slot, other tag

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        look(32'h0000_1ABC, LD, 1'b1); cyc("R1");
        look(VA_A, LD, 1'b1);          cyc("R1");
        look(32'h0000_0FFF, FE, 1'b0); cyc("R1");

        // R8: same-cycle lookup sees old words
        wr(1'b0, 6'd5, 1'b0, TAG_A); look(VA_A, LD, 1'b1); cyc("R8");
        wr(1'b0, 6'd5, 1'b1, XL_A);  look(VA_A, LD, 1'b1); cyc("R8");

        // R5: matches
        look(VA_A, LD, 1'b1); cyc("R5");
        look(VA_A, ST, 1'b1); cyc("R5");
        look(VA_A, LD, 1'b0); cyc("R5");
        // R4: user store without bit 9
        look(VA_A, ST, 1'b0); cyc("R4");

        // R2: other tag in same slot
        look(VA_X, LD, 1'b1); cyc("R2");

        // R7: fetch uses the instruction side
        look(VA_A, FE, 1'b1); cyc("R7");
        wr(1'b1, 6'd5, 1'b0, TAG_A); look(VA_A, FE, 1'b1); cyc("R7");
        wr(1'b1, 6'd5, 1'b1, XL_I);  look(VA_A, FE, 1'b1); cyc("R7");
        look(VA_A, FE, 1'b1); cyc("R7");
        look(VA_A, FE, 1'b0); cyc("R4");
        look(VA_A, 2'b11, 1'b1); cyc("R7");

        // R6: pass-through per side
        cd_on = 1'b0; look(VA_X, ST, 1'b0); cyc("R6");
        look(VA_A, FE, 1'b0); cyc("R6");
        ci_on = 1'b0; look(32'hDEAD_BEEF, FE, 1'b0); cyc("R6");
        cd_on = 1'b1; ci_on = 1'b1;

        // R9: each exception code
        flt = 1'b1; look(VA_X, LD, 1'b1); cyc("R9");
        look(VA_A, LD, 1'b1); cyc("R9");
        flt = 1'b1; look(VA_A, FE, 1'b0); cyc("R9");
        look(VA_A, LD, 1'b1); cyc("R9");
        flt = 1'b1; look(VA_A | 32'h0000_1F00, ST, 1'b0); cyc("R9");
        look(VA_A, LD, 1'b1); cyc("R9");
        flt = 1'b1; look(VA_X, FE, 1'b1); cyc("R9");
        look(VA_A, LD, 1'b1); cyc("R9");

        // R10: hold on strobed match and on unstrobed failure
        flt = 1'b1; look(VA_A, LD, 1'b1); cyc("R10");
        look(VA_A, LD, 1'b1); cyc("R10");
        look(VA_X, ST, 1'b0); cyc("R10");
        look(VA_A, LD, 1'b1); cyc("R10");

        // R3: tag match with valid clear
        wr(1'b0, 6'd5, 1'b0, TAG_A & ~32'h1); look(VA_A, LD, 1'b1); cyc("R3");
        look(VA_A, LD, 1'b1); cyc("R3");
        flt = 1'b1; look(VA_A, ST, 1'b1); cyc("R3");
        look(VA_A, FE, 1'b1); cyc("R9");

        // R8 with R9: write and strobed miss share an edge
        wr(1'b0, 6'd9, 1'b0, {19'h12349, 13'h0001});
        flt = 1'b1; look({19'h12349, 13'h0444}, LD, 1'b1); cyc("R8");
        look({19'h12349, 13'h0444}, LD, 1'b1); cyc("R9");

        // random phase over a small page pool
        for (int n = 0; n < 4000; n++) begin
            logic [18:0] vp;
            vp = {15'(($urandom % 4) << 2), 4'($urandom % 4)};
            if ($urandom % 3 == 0) begin
                logic [18:0] wp;
                wp = {15'(($urandom % 4) << 2), 4'($urandom % 4)};
                if ($urandom % 2 == 0)
                    wr(1'($urandom), wp[5:0], 1'b0,
                       {wp, 12'($urandom), 1'($urandom % 4 != 0)});
                else
                    wr(1'($urandom), wp[5:0], 1'b1, $urandom);
            end
            flt = ($urandom % 4 == 0);
            ci_on = ($urandom % 10 != 0);
            cd_on = ($urandom % 10 != 0);
            look({vp, 13'($urandom)}, 2'($urandom), 1'($urandom));
            cyc("");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule